// File: doc/BRIEF.md
# Accelerator Physical Page Permission Checker

This block stands between one accelerator's physically addressed caches and host memory. Every read or write the accelerator issues is checked against a two-bit permission entry for its physical page before it may pass. The entries live in a flat table in host memory, indexed by page number. A small on-chip cache holds whole groups of entries, and a miss stalls the request while the group is fetched.

Permissions are granted lazily: when the translation unit completes a translation for the accelerator, it sends a grant, and the granted bits are ORed into the page's entry. When permissions shrink, a downgrade is applied. If the page loses write access, the accelerator's TLB entry is invalidated and its dirty blocks for the page are flushed before the new entry is committed. Each accelerator gets its own instance.

Top module: `perm_checker`

## Requirements
- R1: After reset, no request is forwarded, the violation flag is low, and every page has no permission, so the first access to any page is refused.
- R2: The page number is the request address shifted right by PAGE_SHIFT (12). Entry bit 0 grants read and bit 1 grants write. A permitted request is forwarded with its address and direction unchanged.
- R3: A grant ORs its two bits into the page's entry and never clears a bit. The new entry value is written to the table over the write port.
- R4: A refused request is not forwarded. A refused read gives a one-cycle `rd_err_valid`, and a refused write gives a one-cycle `wr_drop_valid`.
- R5: The first refused request sets `viol_flag` and captures its address in `viol_addr`. Both hold until reset, whatever requests are refused later.
- R6: A cache line holds the entries of GROUP_PAGES (512) consecutive pages, line index = page >> 9. Entry k sits in bits [2k+1:2k] of the line. On a miss, exactly one table read is issued for that line and the operation waits for it. A later access to any page of a cached line issues no table read.
- R7: Any update writes the table entry and the cached copy in the same cycle, so a later check of the page uses the new value without a new table read.
- R8: A downgrade sets the entry to old AND keep. If the old entry had write and the new one does not, the block first holds a TLB invalidate until it is acknowledged, then holds a flush for the page until it is acknowledged, and only then writes the table. No other operation is accepted meanwhile.
- R9: A downgrade that does not remove write access writes the new entry at once, with no invalidate and no flush.
- R10: Operations are taken one at a time. When several are offered together, a downgrade is taken first, then a grant, then an access.
- R11: The cache holds NLINES (2) lines and replaces them in round-robin order on fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Accelerator request offered |
| acc_ready | output | 1 | Request taken this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Physical request address |
| fwd_valid | output | 1 | Permitted request passed to host memory |
| fwd_write | output | 1 | Direction of the forwarded request |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| rd_err_valid | output | 1 | Error response for a refused read |
| wr_drop_valid | output | 1 | A refused write was dropped |
| viol_flag | output | 1 | Sticky violation indication |
| viol_addr | output | ADDR_W | Address of the first refused request |
| grt_valid | input | 1 | Grant from the translation unit |
| grt_ready | output | 1 | Grant taken |
| grt_ppn | input | PPN_W | Page of the grant |
| grt_bits | input | 2 | Bits to add (bit0 read, bit1 write) |
| dg_valid | input | 1 | Downgrade offered |
| dg_ready | output | 1 | Downgrade taken |
| dg_ppn | input | PPN_W | Page to downgrade |
| dg_keep | input | 2 | Bits to keep |
| tbl_rd_valid | output | 1 | One-cycle table line read request |
| tbl_rd_lidx | output | LIDX_W | Line index to read |
| tbl_rsp_valid | input | 1 | Table line returned |
| tbl_rsp_line | input | LINE_W | Returned line, entry k at [2k+1:2k] |
| tbl_wr_valid | output | 1 | Table entry write |
| tbl_wr_ppn | output | PPN_W | Page of the entry written |
| tbl_wr_bits | output | 2 | New entry value |
| tlb_inv_valid | output | 1 | TLB invalidate request, held until done |
| tlb_inv_ppn | output | PPN_W | Page to invalidate |
| tlb_inv_done | input | 1 | Invalidate acknowledged |
| flush_valid | output | 1 | Dirty-block flush request, held until done |
| flush_ppn | output | PPN_W | Page to flush |
| flush_done | input | 1 | Flush acknowledged |

## Verification
A cached line that goes stale, or a wrong tag, shows at the ports on the next access to that page. The request is forwarded or refused against the bench's own permission record, or a table read appears where none was due, or is missing where one was due. A misordered downgrade shows at once in the order of invalidate, flush and table write. A wrong merge shows in the table write value of the same operation. The violation register is compared with the bench's record on every clock, so a lost or overwritten capture is seen one cycle after the refusal.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;
   typedef enum logic [1:0] {OP_ACC, OP_GRANT, OP_DOWN} op_e;
   typedef enum logic [2:0] {
      S_IDLE, S_LOOK, S_FREQ, S_FWAIT, S_TLB, S_FLUSH, S_COMMIT
   } st_e;
   localparam int PB_RD = 0;
   localparam int PB_WR = 1;
endpackage

// File: rtl/perm_line_cache.sv
module perm_line_cache #(
   parameter int LIDX_W = 11,
   parameter int OFF_W  = 9,
   parameter int NLINES = 2,
   localparam int LINE_W = 2 * (1 << OFF_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIDX_W-1:0] lk_lidx,
   input  logic [OFF_W-1:0]  lk_off,
   output logic              hit,
   output logic [1:0]        hit_bits,
   input  logic              fill_en,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              upd_en,
   input  logic [1:0]        upd_bits
);
   logic [NLINES-1:0] hit_vec;
   logic [NLINES-1:0] vic_oh;
   logic [1:0]        way_bits [NLINES];

   // victim choice: a single line needs no pointer
   generate
      if (NLINES == 1) begin : g_single
         assign vic_oh = 1'b1;
      end else begin : g_rr
         logic [NLINES-1:0] rr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rr_q <= NLINES'(1);
            else if (fill_en) rr_q <= {rr_q[NLINES-2:0], rr_q[NLINES-1]};
         end
         assign vic_oh = rr_q;
         AST_RR_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rr_q) == 1); // R11
      end
   endgenerate

   generate
      for (genvar w = 0; w < NLINES; w++) begin : g_way
         logic              vld_q;
         logic [LIDX_W-1:0] tag_q;
         logic [LINE_W-1:0] line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               tag_q  <= '0;
               line_q <= '0;
            end else if (fill_en && vic_oh[w]) begin
               vld_q  <= 1'b1;
               tag_q  <= lk_lidx;
               line_q <= fill_line;
            end else if (upd_en && hit_vec[w]) begin
               line_q[{lk_off, 1'b0} +: 2] <= upd_bits;
            end
         end
         assign hit_vec[w]  = vld_q && (tag_q == lk_lidx);
         assign way_bits[w] = line_q[{lk_off, 1'b0} +: 2];
      end
   endgenerate

   always_comb begin
      hit_bits = '0;
      for (int w = 0; w < NLINES; w++)
         if (hit_vec[w]) hit_bits = hit_bits | way_bits[w];
   end
   assign hit = |hit_vec;

   AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R11
   AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !hit); // R6
   AST_UPDATE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |-> hit); // R7
endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl
   import perm_chk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int PPN_W      = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              grt_valid,
   output logic              grt_ready,
   input  logic [PPN_W-1:0]  grt_ppn,
   input  logic [1:0]        grt_bits,
   input  logic              dg_valid,
   output logic              dg_ready,
   input  logic [PPN_W-1:0]  dg_ppn,
   input  logic [1:0]        dg_keep,
   output logic [PPN_W-1:0]  cur_ppn,
   input  logic              cache_hit,
   input  logic [1:0]        cache_bits,
   output logic              fill_en,
   output logic              upd_en,
   output logic [1:0]        upd_bits,
   output logic              fwd_valid,
   output logic              fwd_write,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              rd_err_valid,
   output logic              wr_drop_valid,
   output logic              viol_flag,
   output logic [ADDR_W-1:0] viol_addr,
   output logic              tbl_rd_valid,
   input  logic              tbl_rsp_valid,
   output logic              tbl_wr_valid,
   output logic              tlb_inv_valid,
   input  logic              tlb_inv_done,
   output logic              flush_valid,
   input  logic              flush_done
);
   st_e               st_q;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [PPN_W-1:0]  ppn_q;
   logic [1:0]        arg_q;
   logic [1:0]        newv_q;

   logic       idle, look_hit, allowed, lose_wr, direct_commit, refused;
   logic [1:0] merged, shrunk;

   assign idle      = (st_q == S_IDLE);
   assign dg_ready  = idle && dg_valid;
   assign grt_ready = idle && !dg_valid && grt_valid;
   assign acc_ready = idle && !dg_valid && !grt_valid;

   assign look_hit = (st_q == S_LOOK) && cache_hit;
   assign allowed  = wr_q ? cache_bits[PB_WR] : cache_bits[PB_RD];
   assign merged   = cache_bits | arg_q;
   assign shrunk   = cache_bits & arg_q;
   assign lose_wr  = cache_bits[PB_WR] && !shrunk[PB_WR];
   assign refused  = look_hit && (op_q == OP_ACC) && !allowed;

   assign direct_commit = look_hit &&
      ((op_q == OP_GRANT) || ((op_q == OP_DOWN) && !lose_wr));

   assign fwd_valid     = look_hit && (op_q == OP_ACC) && allowed;
   assign fwd_write     = wr_q;
   assign fwd_addr      = addr_q;
   assign rd_err_valid  = refused && !wr_q;
   assign wr_drop_valid = refused && wr_q;

   assign upd_en        = direct_commit || (st_q == S_COMMIT);
   assign upd_bits      = (st_q == S_COMMIT) ? newv_q :
                          (op_q == OP_GRANT) ? merged : shrunk;
   assign tbl_wr_valid  = upd_en;
   assign tbl_rd_valid  = (st_q == S_FREQ);
   assign fill_en       = (st_q == S_FWAIT) && tbl_rsp_valid;
   assign tlb_inv_valid = (st_q == S_TLB);
   assign flush_valid   = (st_q == S_FLUSH);
   assign cur_ppn       = ppn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         op_q   <= OP_ACC;
         addr_q <= '0;
         wr_q   <= 1'b0;
         ppn_q  <= '0;
         arg_q  <= '0;
         newv_q <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (dg_valid) begin
                  op_q  <= OP_DOWN;
                  ppn_q <= dg_ppn;
                  arg_q <= dg_keep;
                  st_q  <= S_LOOK;
               end else if (grt_valid) begin
                  op_q  <= OP_GRANT;
                  ppn_q <= grt_ppn;
                  arg_q <= grt_bits;
                  st_q  <= S_LOOK;
               end else if (acc_valid) begin
                  op_q   <= OP_ACC;
                  addr_q <= acc_addr;
                  wr_q   <= acc_write;
                  ppn_q  <= acc_addr[ADDR_W-1:PAGE_SHIFT];
                  st_q   <= S_LOOK;
               end
            end
            S_LOOK: begin
               if (!cache_hit) begin
                  st_q <= S_FREQ;
               end else if ((op_q == OP_DOWN) && lose_wr) begin
                  newv_q <= shrunk;
                  st_q   <= S_TLB;
               end else begin
                  st_q <= S_IDLE;
               end
            end
            S_FREQ:   st_q <= S_FWAIT;
            S_FWAIT:  if (tbl_rsp_valid) st_q <= S_LOOK;
            S_TLB:    if (tlb_inv_done)  st_q <= S_FLUSH;
            S_FLUSH:  if (flush_done)    st_q <= S_COMMIT;
            S_COMMIT: st_q <= S_IDLE;
            default:  st_q <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_flag <= 1'b0;
         viol_addr <= '0;
      end else if (refused && !viol_flag) begin
         viol_flag <= 1'b1;
         viol_addr <= addr_q;
      end
   end

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag |=> viol_flag); // R5
   AST_VIOL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag |=> $stable(viol_addr)); // R5
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_valid && (rd_err_valid || wr_drop_valid))); // R4
   AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_valid |=> !tbl_rd_valid); // R6
   AST_NO_WRITE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_inv_valid || flush_valid) |-> !tbl_wr_valid); // R8
   AST_FLUSH_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_valid) |-> $past(tlb_inv_valid)); // R8
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_inv_valid || flush_valid || tbl_rd_valid) |-> !(acc_ready || grt_ready || dg_ready)); // R10
endmodule

// File: rtl/perm_checker.sv
module perm_checker #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int GROUP_PAGES = 512,
   parameter int NLINES      = 2,
   localparam int PPN_W      = ADDR_W - PAGE_SHIFT,
   localparam int GRP_SHIFT  = $clog2(GROUP_PAGES),
   localparam int LIDX_W     = PPN_W - GRP_SHIFT,
   localparam int LINE_W     = 2 * GROUP_PAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              fwd_valid,
   output logic              fwd_write,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              rd_err_valid,
   output logic              wr_drop_valid,
   output logic              viol_flag,
   output logic [ADDR_W-1:0] viol_addr,
   input  logic              grt_valid,
   output logic              grt_ready,
   input  logic [PPN_W-1:0]  grt_ppn,
   input  logic [1:0]        grt_bits,
   input  logic              dg_valid,
   output logic              dg_ready,
   input  logic [PPN_W-1:0]  dg_ppn,
   input  logic [1:0]        dg_keep,
   output logic              tbl_rd_valid,
   output logic [LIDX_W-1:0] tbl_rd_lidx,
   input  logic              tbl_rsp_valid,
   input  logic [LINE_W-1:0] tbl_rsp_line,
   output logic              tbl_wr_valid,
   output logic [PPN_W-1:0]  tbl_wr_ppn,
   output logic [1:0]        tbl_wr_bits,
   output logic              tlb_inv_valid,
   output logic [PPN_W-1:0]  tlb_inv_ppn,
   input  logic              tlb_inv_done,
   output logic              flush_valid,
   output logic [PPN_W-1:0]  flush_ppn,
   input  logic              flush_done
);
   initial begin
      assert (GROUP_PAGES >= 2 && (GROUP_PAGES & (GROUP_PAGES - 1)) == 0)
         else $error("GROUP_PAGES must be a power of two of at least 2");
      assert (PAGE_SHIFT > 0 && PPN_W > GRP_SHIFT)
         else $error("address too narrow for page and group sizes");
      assert (NLINES >= 1) else $error("NLINES must be at least 1");
   end

   logic [PPN_W-1:0] cur_ppn;
   logic             cache_hit, fill_en, upd_en;
   logic [1:0]       cache_bits, upd_bits;

   perm_ctrl #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_ready(acc_ready),
      .acc_write(acc_write), .acc_addr(acc_addr),
      .grt_valid(grt_valid), .grt_ready(grt_ready),
      .grt_ppn(grt_ppn), .grt_bits(grt_bits),
      .dg_valid(dg_valid), .dg_ready(dg_ready),
      .dg_ppn(dg_ppn), .dg_keep(dg_keep),
      .cur_ppn(cur_ppn), .cache_hit(cache_hit), .cache_bits(cache_bits),
      .fill_en(fill_en), .upd_en(upd_en), .upd_bits(upd_bits),
      .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
      .rd_err_valid(rd_err_valid), .wr_drop_valid(wr_drop_valid),
      .viol_flag(viol_flag), .viol_addr(viol_addr),
      .tbl_rd_valid(tbl_rd_valid), .tbl_rsp_valid(tbl_rsp_valid),
      .tbl_wr_valid(tbl_wr_valid),
      .tlb_inv_valid(tlb_inv_valid), .tlb_inv_done(tlb_inv_done),
      .flush_valid(flush_valid), .flush_done(flush_done)
   );

   perm_line_cache #(
      .LIDX_W(LIDX_W), .OFF_W(GRP_SHIFT), .NLINES(NLINES)
   ) u_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_lidx(cur_ppn[PPN_W-1:GRP_SHIFT]),
      .lk_off(cur_ppn[GRP_SHIFT-1:0]),
      .hit(cache_hit), .hit_bits(cache_bits),
      .fill_en(fill_en), .fill_line(tbl_rsp_line),
      .upd_en(upd_en), .upd_bits(upd_bits)
   );

   assign tbl_rd_lidx = cur_ppn[PPN_W-1:GRP_SHIFT];
   assign tbl_wr_ppn  = cur_ppn;
   assign tbl_wr_bits = upd_bits;
   assign tlb_inv_ppn = cur_ppn;
   assign flush_ppn   = cur_ppn;

   AST_GRANT_TAKEN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({acc_ready && acc_valid, grt_ready, dg_ready}) <= 1); // R10
   AST_TBL_WR_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_wr_valid |-> !(fwd_valid || rd_err_valid || wr_drop_valid)); // R7
endmodule

// File: tb/tb_perm_checker.sv
`timescale 1ns/1ps
module tb_perm_checker;
   localparam int ADDR_W = 32;
   localparam int PPN_W  = 20;
   localparam int GRP    = 512;
   localparam int LIDX_W = 11;
   localparam int LINE_W = 2 * GRP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              acc_valid = 0, acc_write = 0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic              acc_ready, fwd_valid, fwd_write, rd_err_valid, wr_drop_valid, viol_flag;
   logic [ADDR_W-1:0] fwd_addr, viol_addr;
   logic              grt_valid = 0, dg_valid = 0, grt_ready, dg_ready;
   logic [PPN_W-1:0]  grt_ppn = '0, dg_ppn = '0;
   logic [1:0]        grt_bits = '0, dg_keep = '0;
   logic              tbl_rd_valid, tbl_rsp_valid = 0, tbl_wr_valid;
   logic [LIDX_W-1:0] tbl_rd_lidx;
   logic [LINE_W-1:0] tbl_rsp_line = '0;
   logic [PPN_W-1:0]  tbl_wr_ppn, tlb_inv_ppn, flush_ppn;
   logic [1:0]        tbl_wr_bits;
   logic              tlb_inv_valid, tlb_inv_done = 0, flush_valid, flush_done = 0;

   perm_checker dut (.*);

   int n_checks = 0, n_err = 0;
   logic [1:0] tbl_m [int];
   logic [1:0] ref_m [int];
   int ev_q [$];
   int rd_cnt = 0, wr_cnt = 0, fwd_cnt = 0, rde_cnt = 0, wrd_cnt = 0;
   logic [ADDR_W-1:0] last_fwd_addr, cur_addr = '0, exp_vaddr = '0;
   logic last_fwd_write, exp_viol = 0;
   int last_rd_lidx, last_tlb_ppn, last_flush_ppn;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [1:0] tget(int p);
      return tbl_m.exists(p) ? tbl_m[p] : 2'b00;
   endfunction
   function automatic logic [1:0] rget(int p);
      return ref_m.exists(p) ? ref_m[p] : 2'b00;
   endfunction

   // table memory: line reads and entry writes
   initial forever begin
      @(negedge clk);
      if (rst_n && tbl_rd_valid) begin
         int li;
         li = int'(tbl_rd_lidx);
         last_rd_lidx = li;
         rd_cnt++;
         repeat (3) @(negedge clk);
         for (int k = 0; k < GRP; k++) tbl_rsp_line[2*k +: 2] = tget(li * GRP + k);
         tbl_rsp_valid = 1;
         @(negedge clk);
         tbl_rsp_valid = 0;
      end
   end
   initial forever begin
      @(negedge clk);
      if (rst_n && tlb_inv_valid) begin
         ev_q.push_back(1);
         last_tlb_ppn = int'(tlb_inv_ppn);
         repeat (2) @(negedge clk);
         tlb_inv_done = 1;
         @(negedge clk);
         tlb_inv_done = 0;
      end
   end
   initial forever begin
      @(negedge clk);
      if (rst_n && flush_valid) begin
         ev_q.push_back(2);
         last_flush_ppn = int'(flush_ppn);
         repeat (2) @(negedge clk);
         flush_done = 1;
         @(negedge clk);
         flush_done = 0;
      end
   end

   // per-clock monitor and violation reference model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(viol_flag === exp_viol, "R5", "viol_flag", viol_flag, exp_viol);
         if (exp_viol)
            chk(viol_addr === exp_vaddr, "R5", "viol_addr", viol_addr, exp_vaddr);
         if (tbl_wr_valid) begin
            tbl_m[int'(tbl_wr_ppn)] = tbl_wr_bits;
            ev_q.push_back(3);
            wr_cnt++;
         end
         if (fwd_valid) begin
            last_fwd_addr = fwd_addr;
            last_fwd_write = fwd_write;
            fwd_cnt++;
         end
         if (rd_err_valid) rde_cnt++;
         if (wr_drop_valid) wrd_cnt++;
         if ((rd_err_valid || wr_drop_valid) && !exp_viol) begin
            exp_viol = 1;
            exp_vaddr = cur_addr;
         end
      end
   end

   task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                         input int exp_reads, input string rq);
      int r0, o0, f0;
      bit exp_ok;
      exp_ok = wr ? rget(int'(a >> 12))[1] : rget(int'(a >> 12))[0];
      r0 = rd_cnt; f0 = fwd_cnt; o0 = fwd_cnt + rde_cnt + wrd_cnt;
      @(negedge clk);
      cur_addr = a; acc_addr = a; acc_write = wr; acc_valid = 1;
      #1;
      while (!acc_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      acc_valid = 0;
      wait (fwd_cnt + rde_cnt + wrd_cnt != o0);
      #1;
      chk((fwd_cnt != f0) == exp_ok, rq, "forwarded", fwd_cnt - f0, exp_ok);
      if (exp_ok) begin
         chk(last_fwd_addr === a, rq, "fwd_addr", last_fwd_addr, a);
         chk(last_fwd_write === wr, rq, "fwd_write", last_fwd_write, wr);
      end else if (wr) chk(wrd_cnt > 0, rq, "write drop pulse", wrd_cnt, 1);
      else chk(rde_cnt > 0, rq, "read error pulse", rde_cnt, 1);
      chk(rd_cnt - r0 == exp_reads, rq, "table reads", rd_cnt - r0, exp_reads);
   endtask

   task automatic grant(input int p, input logic [1:0] b,
                        input int exp_reads, input string rq);
      int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      ref_m[p] = rget(p) | b;
      @(negedge clk);
      grt_ppn = PPN_W'(p); grt_bits = b; grt_valid = 1;
      #1;
      while (!grt_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      grt_valid = 0;
      wait (wr_cnt != w0);
      #1;
      chk(tget(p) === rget(p), rq, "table entry after grant", tget(p), rget(p));
      chk(rd_cnt - r0 == exp_reads, rq, "table reads", rd_cnt - r0, exp_reads);
   endtask

   task automatic downgrade(input int p, input logic [1:0] keep, input string rq);
      int w0;
      bit seq;
      seq = rget(p)[1] && !keep[1];
      ref_m[p] = rget(p) & keep;
      ev_q.delete();
      w0 = wr_cnt;
      @(negedge clk);
      dg_ppn = PPN_W'(p); dg_keep = keep; dg_valid = 1;
      #1;
      while (!dg_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      dg_valid = 0;
      wait (wr_cnt != w0);
      #1;
      if (seq) begin
         chk(ev_q.size() == 3, rq, "event count", ev_q.size(), 3);
         if (ev_q.size() == 3) begin
            chk(ev_q[0] == 1, rq, "first event is invalidate", ev_q[0], 1);
            chk(ev_q[1] == 2, rq, "second event is flush", ev_q[1], 2);
            chk(ev_q[2] == 3, rq, "table write last", ev_q[2], 3);
         end
         chk(last_tlb_ppn == p, rq, "invalidate page", last_tlb_ppn, p);
         chk(last_flush_ppn == p, rq, "flush page", last_flush_ppn, p);
      end else begin
         chk(ev_q.size() == 1 && ev_q[0] == 3, rq, "only a table write", ev_q.size(), 1);
      end
      chk(tget(p) === rget(p), rq, "table entry after downgrade", tget(p), rget(p));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R1: idle after reset
      chk(fwd_valid === 0, "R1", "fwd_valid", fwd_valid, 0);
      chk(viol_flag === 0, "R1", "viol_flag", viol_flag, 0);
      chk(tbl_rd_valid === 0 && tlb_inv_valid === 0 && flush_valid === 0,
          "R1", "no requests", 1, 0);
      chk(acc_ready === 1, "R1", "acc_ready", acc_ready, 1);

      access(0, 32'h0000_5000, 1, "R1 R2 R4 R6 first read refused");
      chk(last_rd_lidx == 0, "R6", "line index", last_rd_lidx, 0);
      grant(5, 2'b01, 0, "R3 R7 read grant on cached line");
      access(0, 32'h0000_5abc, 0, "R2 R7 read allowed");
      access(1, 32'h0000_5010, 0, "R4 R5 write refused");
      grant(5, 2'b10, 0, "R3 write grant ORed");
      access(1, 32'h0000_5010, 0, "R2 write allowed");
      grant(5, 2'b00, 0, "R3 empty grant keeps bits");
      access(0, 32'h001F_F000, 0, "R6 last page of same line");
      access(0, 32'h0020_0000, 1, "R6 next line fetched");
      chk(last_rd_lidx == 1, "R6", "line index", last_rd_lidx, 1);
      grant(32'h12345, 2'b11, 1, "R11 fill evicts first way");
      access(0, 32'h0000_5000, 1, "R11 R7 refetch keeps grant");
      access(0, 32'h1234_5000, 0, "R11 line still cached");
      access(0, 32'h0020_0000, 1, "R11 round robin victim");
      downgrade(5, 2'b01, "R8 write removed");
      access(1, 32'h0000_5000, 0, "R8 write refused after downgrade");
      access(0, 32'h0000_5000, 0, "R8 read still allowed");
      downgrade(5, 2'b00, "R9 read-only downgrade");
      access(0, 32'h0000_5000, 0, "R9 read refused");

      // R10: downgrade, grant and access offered in the same cycle
      begin
         int order [$];
         int o0;
         o0 = rde_cnt;
         ev_q.delete();
         ref_m[32'h12345] = 2'b00;
         ref_m[7] = rget(7) | 2'b01;
         @(negedge clk);
         dg_ppn = 20'h12345; dg_keep = 2'b00; dg_valid = 1;
         grt_ppn = 20'd7; grt_bits = 2'b01; grt_valid = 1;
         cur_addr = 32'h1234_5008; acc_addr = 32'h1234_5008; acc_write = 0; acc_valid = 1;
         for (int c = 0; c < 400 && (dg_valid || grt_valid || acc_valid); c++) begin
            #1;
            if (dg_valid && dg_ready) begin
               order.push_back(3); @(negedge clk); dg_valid = 0;
            end else if (grt_valid && grt_ready) begin
               order.push_back(2); @(negedge clk); grt_valid = 0;
            end else if (acc_valid && acc_ready) begin
               order.push_back(1); @(negedge clk); acc_valid = 0;
            end else @(negedge clk);
         end
         chk(order.size() == 3, "R10", "accepted count", order.size(), 3);
         if (order.size() == 3) begin
            chk(order[0] == 3, "R10", "downgrade first", order[0], 3);
            chk(order[1] == 2, "R10", "grant second", order[1], 2);
            chk(order[2] == 1, "R10", "access last", order[2], 1);
         end
         wait (rde_cnt != o0);
         #1;
         chk(tget(32'h12345) === 2'b00, "R10 R8", "downgraded entry", tget(32'h12345), 0);
         chk(tget(7) === 2'b01, "R10 R3", "granted entry", tget(7), 1);
         chk(ev_q.size() >= 2 && ev_q[0] == 1 && ev_q[1] == 2, "R10 R8",
             "invalidate then flush", ev_q.size(), 4);
      end

      repeat (3) @(negedge clk);
      chk(viol_addr === 32'h0000_5000, "R5", "first violation kept", viol_addr, 32'h5000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule